// File: doc/BRIEF.md
# I2C Fault-Injecting Bus Master

This block is an open-drain I2C controller that has two jobs. It can run an ordinary register read against a target, or it can abandon a transfer partway through a byte on purpose. When it abandons a transfer it leaves SCL pulled low and sends no stop condition, so the bus stays stuck. Firmware uses the stuck bus to exercise recovery paths in other agents on the same bus. A single go strobe starts a command. The command is built from a target address held in bits 7..1 of `cmd_addr`, a register or data byte, a three-bit mode field and an optional bit count.

Both bus lines are driven only by pulling them low through output enables, and both are sampled through a synchroniser. Every bit is timed by a programmable delay counter. The high phase of each clock waits until SCL actually reads high, so a target can stretch the clock. That wait has a timeout, and on timeout the command is abandoned with an error flag rather than hanging. When a command finishes, the block reports a one-cycle done pulse, the acknowledge result of each address byte, and the data it read. In wedge modes it can also raise a one-cycle reset request.

Top module: `i2c_fault_master`

## Requirements
- R1: After reset both output enables are low (both lines released), and busy, done and rst_req are low.
- R2: Address bytes go out MSB first as cmd_addr[7:1] followed by a direction bit. The direction bit is 0 for the write-phase address and 1 for the read-phase address, and cmd_addr[0] is ignored.
- R3: After every byte the master writes, it gives one extra clock and samples SDA. A high level means NACK. The result for the write-phase address appears on nack_wr and the result for the read-phase address on nack_rd, both valid at done.
- R4: Mode 0 or 4 runs a normal transfer: start, write-phase address, register byte, repeated start, read-phase address, then two bytes read. The first byte is answered with ACK and the second with NACK, and a stop follows. The bytes appear on rd_first and rd_second, and both lines are released at done.
- R5: cmd_mode bit 0 selects a wedged write and bit 1 a wedged read. When both are set, bit 0 wins. A mode with neither bit set is a normal transfer.
- R6: The bit count is taken from cmd_cnt only when cmd_cnt_vld is high, and values above 8 act as 8. When cmd_cnt_vld is low the count is 8 for a wedged write and 2 for a wedged read.
- R7: A wedged write sends start and the write-phase address, then the ACK clock, then exactly the chosen number of bits of cmd_data MSB first. It gives no ACK clock for that data and sends no stop, and SCL stays pulled low after done.
- R8: A wedged read runs the normal preamble up to the read-phase address. It then clocks in the chosen number of bits, shifting them into the LSB end of rd_first (which starts at zero), and sends no ACK and no stop. SCL stays pulled low after done.
- R9: rst_req pulses for one cycle together with done only when a wedge mode was chosen and cmd_mode bit 2 is set.
- R10: Each clock high phase starts only after SCL reads high, so a stretched clock delays the transfer without changing any data. If SCL stays low for STRETCH_LIMIT cycles, the command is abandoned: both lines are released, stretch_err goes high and done pulses.
- R11: A go strobe that arrives while busy is ignored, and every command yields exactly one single-cycle done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Command start strobe |
| cmd_addr | input | 8 | Target address in bits 7..1 |
| cmd_data | input | 8 | Register byte, or data byte for a wedged write |
| cmd_mode | input | 3 | Bit 0 wedged write, bit 1 wedged read, bit 2 reset request |
| cmd_cnt_vld | input | 1 | Use cmd_cnt instead of the default count |
| cmd_cnt | input | 4 | Bits to send or receive before wedging |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| stretch_err | output | 1 | Last command abandoned on clock-stretch timeout |
| nack_wr | output | 1 | NACK on the write-phase address |
| nack_rd | output | 1 | NACK on the read-phase address |
| rd_first | output | 8 | First read byte, or the partial bits of a wedged read |
| rd_second | output | 8 | Second read byte |
| rst_req | output | 1 | One-cycle reset request after a wedge |

## Verification
The bench builds the block with DLY_CYC = 4 and STRETCH_LIMIT = 64. With these values a full normal transfer takes only a few hundred cycles, so every mode and bit count fits in one short run next to a bus target model that stretches the clock. The small limit also lets the bench hold SCL low until the timeout fires and watch the abandon path, which the default limit would put far out of reach. A 20-cycle stretch stays well under the limit, so it must slow the transfer without changing any data.

// File: rtl/i2c_fm_pkg.sv
package i2c_fm_pkg;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WBIT, OP_RBIT} op_e;
  typedef enum logic [1:0] {K_NORMAL, K_WR, K_RD} kind_e;
  typedef enum logic [3:0] {
    Q_IDLE, Q_START, Q_ADDR_W, Q_REG, Q_RSTART, Q_ADDR_R,
    Q_RD0, Q_RD1, Q_STOP, Q_PART
  } seq_e;

  // mode decode: write wedge has priority over read wedge
  function automatic kind_e kind_of(input logic [2:0] m);
    if (m[0]) return K_WR;
    if (m[1]) return K_RD;
    return K_NORMAL;
  endfunction

  function automatic logic [3:0] eff_count(input kind_e k, input logic vld,
                                           input logic [3:0] c);
    if (!vld) return (k == K_RD) ? 4'd2 : 4'd8;
    return (c > 4'd8) ? 4'd8 : c;
  endfunction

  function automatic logic [7:0] addr_byte(input logic [7:0] a, input logic rd);
    return {a[7:1], rd};
  endfunction

  // bit number idx counted from the MSB
  function automatic logic msb_at(input logic [7:0] b, input logic [3:0] idx);
    logic [7:0] t;
    t = b << idx;
    return t[7];
  endfunction

endpackage

// File: rtl/i2c_fm_sync.sv
module i2c_fm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_fm_engine.sv
module i2c_fm_engine
  import i2c_fm_pkg::*;
#(
  parameter int DLY_CYC       = 500,
  parameter int STRETCH_LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  op_e  op,
  input  logic tx_bit,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_oe,
  output logic sda_oe,
  output logic fin,
  output logic tmo,
  output logic rx_bit
);
  localparam int TW = $clog2(DLY_CYC + 1);
  localparam int WW = $clog2(STRETCH_LIMIT + 1);
  localparam logic [TW-1:0] DLY_LD  = TW'(DLY_CYC - 1);
  localparam logic [WW-1:0] WAIT_MX = WW'(STRETCH_LIMIT - 1);

  typedef enum logic [2:0] {E_IDLE, E_SET, E_RISE, E_HIGH, E_TAIL} est_e;
  est_e           st;
  op_e            op_q;
  logic [TW-1:0]  tmr;
  logic [WW-1:0]  wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= E_IDLE;
      op_q     <= OP_START;
      tmr      <= '0;
      wait_cnt <= '0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      fin      <= 1'b0;
      tmo      <= 1'b0;
      rx_bit   <= 1'b0;
    end else begin
      fin <= 1'b0;
      tmo <= 1'b0;
      case (st)
        E_IDLE: if (req) begin
          op_q   <= op;
          sda_oe <= (op == OP_STOP) || (op == OP_WBIT && !tx_bit);
          tmr    <= DLY_LD;
          st     <= E_SET;
        end
        E_SET: if (tmr == '0) begin
          scl_oe   <= 1'b0;
          wait_cnt <= '0;
          st       <= E_RISE;
        end else tmr <= tmr - 1'b1;
        E_RISE: if (scl_s) begin
          tmr <= DLY_LD;
          st  <= E_HIGH;
        end else if (wait_cnt == WAIT_MX) begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
          tmo    <= 1'b1;
          fin    <= 1'b1;
          st     <= E_IDLE;
        end else wait_cnt <= wait_cnt + 1'b1;
        E_HIGH: if (tmr == '0) begin
          rx_bit <= sda_s;
          case (op_q)
            OP_START: begin sda_oe <= 1'b1; tmr <= DLY_LD; st <= E_TAIL; end
            OP_STOP:  begin sda_oe <= 1'b0; tmr <= DLY_LD; st <= E_TAIL; end
            default:  begin scl_oe <= 1'b1; fin <= 1'b1; st <= E_IDLE; end
          endcase
        end else tmr <= tmr - 1'b1;
        E_TAIL: if (tmr == '0) begin
          if (op_q == OP_START) scl_oe <= 1'b1;
          fin <= 1'b1;
          st  <= E_IDLE;
        end else tmr <= tmr - 1'b1;
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_fault_master.sv
module i2c_fault_master
  import i2c_fm_pkg::*;
#(
  parameter int DLY_CYC       = 500,
  parameter int STRETCH_LIMIT = 100000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] cmd_addr,
  input  logic [7:0] cmd_data,
  input  logic [2:0] cmd_mode,
  input  logic       cmd_cnt_vld,
  input  logic [3:0] cmd_cnt,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       busy,
  output logic       done,
  output logic       stretch_err,
  output logic       nack_wr,
  output logic       nack_rd,
  output logic [7:0] rd_first,
  output logic [7:0] rd_second,
  output logic       rst_req
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  seq_e       q;
  kind_e      kind_q;
  logic       reboot_q;
  logic [7:0] addr_q, data_q, tx_byte;
  logic [3:0] cnt_q, bitn;
  logic       inflight;
  op_e        op_n;
  logic       bit_n;
  logic [1:0] line_s;
  logic       op_fin, op_tmo, op_rx;

  // named internal events, also seen by the checker
  logic op_fire, part_end, seq_fin, wedge_sel;

  i2c_fm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
  );

  i2c_fm_engine #(.DLY_CYC(DLY_CYC), .STRETCH_LIMIT(STRETCH_LIMIT)) u_eng (
    .clk(clk), .rst_n(rst_n), .req(op_fire), .op(op_n), .tx_bit(bit_n),
    .scl_s(line_s[1]), .sda_s(line_s[0]), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .fin(op_fin), .tmo(op_tmo), .rx_bit(op_rx)
  );

  always_comb begin
    case (q)
      Q_ADDR_W: tx_byte = addr_byte(addr_q, 1'b0);
      Q_ADDR_R: tx_byte = addr_byte(addr_q, 1'b1);
      default:  tx_byte = data_q;
    endcase
  end

  always_comb begin
    op_n  = OP_WBIT;
    bit_n = 1'b1;
    case (q)
      Q_START, Q_RSTART: op_n = OP_START;
      Q_STOP:            op_n = OP_STOP;
      Q_ADDR_W, Q_REG, Q_ADDR_R:
        if (bitn == ACK_SLOT) op_n = OP_RBIT;
        else                  bit_n = msb_at(tx_byte, bitn);
      Q_RD0, Q_RD1:
        if (bitn == ACK_SLOT) bit_n = (q == Q_RD1);
        else                  op_n = OP_RBIT;
      Q_PART:
        if (kind_q == K_RD) op_n = OP_RBIT;
        else                bit_n = msb_at(data_q, bitn);
      default: ;
    endcase
  end

  assign busy      = (q != Q_IDLE);
  assign wedge_sel = (kind_q != K_NORMAL);
  assign part_end  = (q == Q_PART) && (bitn == cnt_q);
  assign op_fire   = busy && !inflight && !part_end;
  assign seq_fin   = (op_fin && (op_tmo || q == Q_STOP)) || (part_end && !inflight);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= Q_IDLE; kind_q <= K_NORMAL; reboot_q <= 1'b0;
      addr_q <= '0; data_q <= '0; cnt_q <= '0; bitn <= '0; inflight <= 1'b0;
      done <= 1'b0; rst_req <= 1'b0; stretch_err <= 1'b0;
      nack_wr <= 1'b0; nack_rd <= 1'b0; rd_first <= '0; rd_second <= '0;
    end else begin
      done    <= 1'b0;
      rst_req <= 1'b0;
      if (q == Q_IDLE) begin
        if (go) begin
          addr_q   <= cmd_addr;
          data_q   <= cmd_data;
          kind_q   <= kind_of(cmd_mode);
          reboot_q <= cmd_mode[2];
          cnt_q    <= eff_count(kind_of(cmd_mode), cmd_cnt_vld, cmd_cnt);
          bitn     <= '0;
          nack_wr  <= 1'b0; nack_rd <= 1'b0; stretch_err <= 1'b0;
          rd_first <= '0;   rd_second <= '0;
          q        <= Q_START;
        end
      end else begin
        if (op_fire)     inflight <= 1'b1;
        else if (op_fin) inflight <= 1'b0;
        if (seq_fin) begin
          q           <= Q_IDLE;
          done        <= 1'b1;
          stretch_err <= op_fin && op_tmo;
          rst_req     <= wedge_sel && reboot_q && !(op_fin && op_tmo);
        end else if (op_fin) begin
          case (q)
            Q_START:  begin q <= Q_ADDR_W; bitn <= '0; end
            Q_RSTART: begin q <= Q_ADDR_R; bitn <= '0; end
            Q_ADDR_W, Q_REG, Q_ADDR_R:
              if (bitn == ACK_SLOT) begin
                bitn <= '0;
                if (q == Q_ADDR_W) begin
                  nack_wr <= op_rx;
                  q <= (kind_q == K_WR) ? Q_PART : Q_REG;
                end else if (q == Q_REG) q <= Q_RSTART;
                else begin
                  nack_rd <= op_rx;
                  q <= (kind_q == K_RD) ? Q_PART : Q_RD0;
                end
              end else bitn <= bitn + 4'd1;
            Q_RD0, Q_RD1:
              if (bitn == ACK_SLOT) begin
                bitn <= '0;
                q    <= (q == Q_RD0) ? Q_RD1 : Q_STOP;
              end else begin
                if (q == Q_RD0) rd_first  <= {rd_first[6:0], op_rx};
                else            rd_second <= {rd_second[6:0], op_rx};
                bitn <= bitn + 4'd1;
              end
            Q_PART: begin
              if (kind_q == K_RD) rd_first <= {rd_first[6:0], op_rx};
              bitn <= bitn + 4'd1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_fm_checker.sv
module i2c_fm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       busy,
  input logic       rst_req,
  input logic       stretch_err,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       wedge_sel,
  input logic [7:0] lat_addr
);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(lat_addr));

  p_reboot_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (done && wedge_sel));

  p_wedge_holds_scl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wedge_sel && !stretch_err) |-> scl_oe);

  p_normal_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wedge_sel && !stretch_err) |-> (!scl_oe && !sda_oe));

  p_timeout_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stretch_err) |-> (done && !scl_oe && !sda_oe && !rst_req));
endmodule

bind i2c_fault_master i2c_fm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .rst_req(rst_req),
  .stretch_err(stretch_err), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .wedge_sel(wedge_sel), .lat_addr(addr_q)
);

// File: tb/sim_i2c_fault_master.sv
module sim_i2c_fault_master;
  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 4;
  localparam int LIMIT      = 64;
  localparam logic [6:0] TGT = 7'h2C;

  typedef struct {
    string tag; logic err, nw, nr, rst; logic [7:0] r0, r1;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [7:0] cmd_addr = '0, cmd_data = '0;
  logic [2:0] cmd_mode = '0;
  logic cmd_cnt_vld = 1'b0;
  logic [3:0] cmd_cnt = '0;
  logic scl_oe, sda_oe, busy, done, stretch_err, nack_wr, nack_rd, rst_req;
  logic [7:0] rd_first, rd_second;

  // bus target model state
  logic t_pull = 1'b0, t_stuck = 1'b0, tclr = 1'b0, trw = 1'b0;
  int t_hold = 0, t_stretch = 0, tbit = 0, tphase = 0, tidx = 0;
  int starts = 0, stops = 0;
  logic ps = 1'b1, pd = 1'b1;
  logic [7:0] tsh = '0, treg = '0, ttx = '0, alog0 = '0, alog1 = '0;

  wire scl_l = !(scl_oe || t_hold > 0 || t_stuck);
  wire sda_l = !(sda_oe || t_pull);

  int nchk = 0, nfail = 0, done_seen = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_fault_master #(.DLY_CYC(DLY), .STRETCH_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_mode(cmd_mode), .cmd_cnt_vld(cmd_cnt_vld), .cmd_cnt(cmd_cnt),
    .scl_in(scl_l), .sda_in(sda_l), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .done(done), .stretch_err(stretch_err), .nack_wr(nack_wr),
    .nack_rd(nack_rd), .rd_first(rd_first), .rd_second(rd_second), .rst_req(rst_req)
  );

  function automatic logic [7:0] tbyte(input logic [7:0] r, input int i);
    return (i == 0) ? (r ^ 8'h5A) : ~r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // target: reacts on the falling clock edge, away from the design's edge
  always @(negedge clk) begin
    if (tclr) begin
      tphase = 0; t_pull = 1'b0; t_hold = 0; starts = 0; stops = 0;
      tbit = 0; tsh = '0;
    end else begin
      if (t_hold > 0) t_hold--;
      if (ps && scl_l && pd && !sda_l) begin
        starts++; tphase = 1; tbit = 0; tsh = '0; t_pull = 1'b0;
      end else if (ps && scl_l && !pd && sda_l) begin
        stops++; tphase = 0; t_pull = 1'b0;
      end else if (!ps && scl_l) begin
        if ((tphase == 1 || tphase == 2) && tbit < 8) begin
          tsh = {tsh[6:0], sda_l}; tbit++;
        end else if ((tphase == 1 || tphase == 2) && tbit == 8) tbit = 9;
        else if (tphase == 3) begin
          if (tbit < 8) tbit++;
          else begin
            tbit = 9;
            if (sda_l) tphase = 4;
            else begin tidx++; ttx = tbyte(treg, tidx); end
          end
        end
      end else if (ps && !scl_l) begin
        t_hold = t_stretch;
        if (tphase == 1 || tphase == 2) begin
          if (tbit == 8) begin
            if (tphase == 1) begin
              if (starts == 1) alog0 = tsh; else alog1 = tsh;
              if (tsh[7:1] == TGT) begin t_pull = 1'b1; trw = tsh[0]; end
              else tphase = 4;
            end else begin t_pull = 1'b1; treg = tsh; end
          end else if (tbit == 9) begin
            t_pull = 1'b0;
            if (tphase == 1 && trw) begin
              tphase = 3; tidx = 0; ttx = tbyte(treg, 0); tbit = 0; t_pull = !ttx[7];
            end else if (tphase == 1) begin tphase = 2; tbit = 0; tsh = '0; end
            else tphase = 4;
          end
        end else if (tphase == 3) begin
          if (tbit >= 1 && tbit < 8) t_pull = !ttx[7-tbit];
          else if (tbit == 8) t_pull = 1'b0;
          else if (tbit == 9) begin tbit = 0; t_pull = !ttx[7]; end
        end
      end
    end
    ps = scl_l; pd = sda_l;
  end

  // monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      done_seen++;
      if (sb.size() == 0) chk(1'b0, "R11 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(stretch_err == e.err, {e.tag, " stretch_err"}, stretch_err, e.err);
        chk(nack_wr == e.nw, {e.tag, " R3 nack_wr"}, nack_wr, e.nw);
        chk(nack_rd == e.nr, {e.tag, " R3 nack_rd"}, nack_rd, e.nr);
        chk(rd_first == e.r0, {e.tag, " rd_first"}, rd_first, e.r0);
        chk(rd_second == e.r1, {e.tag, " rd_second"}, rd_second, e.r1);
        chk(rst_req == e.rst, {e.tag, " R9 rst_req"}, rst_req, e.rst);
      end
    end
  end

  function automatic exp_t mk(input string t, input logic er, nw, nr,
                              input logic [7:0] r0, r1, input logic rs);
    exp_t e;
    e.tag = t; e.err = er; e.nw = nw; e.nr = nr; e.r0 = r0; e.r1 = r1; e.rst = rs;
    return e;
  endfunction

  task automatic tgt_clear();
    @(posedge clk); tclr = 1'b1;
    @(posedge clk); tclr = 1'b0;
  endtask

  task automatic issue(input logic [7:0] a, d, input logic [2:0] m,
                       input logic v, input logic [3:0] c);
    @(negedge clk);
    cmd_addr = a; cmd_data = d; cmd_mode = m; cmd_cnt_vld = v; cmd_cnt = c; go = 1'b1;
    @(negedge clk); go = 1'b0;
  endtask

  task automatic run(input logic [7:0] a, d, input logic [2:0] m,
                     input logic v, input logic [3:0] c, input exp_t e);
    int n0;
    tgt_clear();
    sb.push_back(e);
    n0 = done_seen;
    issue(a, d, m, v, c);
    wait (done_seen != n0);
    @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk({scl_oe, sda_oe, busy, done, rst_req} == 5'b0, "R1 reset outputs",
        {scl_oe, sda_oe, busy, done, rst_req}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy, "R1 idle after reset", {scl_oe, sda_oe, busy}, 0);

    // normal transfer, address bit 0 set on input must be ignored
    run(8'h59, 8'h13, 3'd0, 1'b0, 4'd0, mk("R4 normal", 0, 0, 0, 8'h13 ^ 8'h5A, ~8'h13, 0));
    chk(alog0 == 8'h58, "R2 write address byte", alog0, 8'h58);
    chk(alog1 == 8'h59, "R2 read address byte", alog1, 8'h59);
    chk(stops == 1, "R4 one stop", stops, 1);
    chk(scl_l && sda_l, "R4 lines released", {scl_l, sda_l}, 2'b11);

    // absent target: both address bytes NACKed, read bytes all ones
    run(8'h60, 8'h22, 3'd0, 1'b0, 4'd0, mk("R3 nack", 0, 1, 1, 8'hFF, 8'hFF, 0));

    // wedged write, 3 bits of A6
    run(8'h58, 8'hA6, 3'd1, 1'b1, 4'd3, mk("R7 wedge write", 0, 0, 0, 0, 0, 0));
    chk(tbit == 3, "R7 bit count", tbit, 3);
    chk(tsh == (8'hA6 >> 5), "R7 bits MSB first", tsh, 8'hA6 >> 5);
    chk(stops == 0, "R7 no stop", stops, 0);
    chk(!scl_l, "R7 SCL held low", scl_l, 0);

    // both wedge bits set: write wins, default count 8
    run(8'h58, 8'h3C, 3'd3, 1'b0, 4'd0, mk("R5 mode priority", 0, 0, 0, 0, 0, 0));
    chk(tbit == 8 && tsh == 8'h3C, "R5 R6 write default 8", {tbit[7:0], tsh}, 16'h083C);

    // count above 8 clamps to 8
    run(8'h58, 8'h81, 3'd1, 1'b1, 4'd12, mk("R6 clamp", 0, 0, 0, 0, 0, 0));
    chk(tbit == 8 && tsh == 8'h81, "R6 clamp to 8", {tbit[7:0], tsh}, 16'h0881);

    // wedged read with reboot, 5 bits
    run(8'h58, 8'hC3, 3'd6, 1'b1, 4'd5,
        mk("R8 wedge read", 0, 0, 0, (8'hC3 ^ 8'h5A) >> 3, 0, 1));
    chk(stops == 0 && !scl_l, "R8 no stop, SCL low", {stops[7:0], scl_l}, 0);

    // wedged read with default count 2
    run(8'h58, 8'h47, 3'd2, 1'b0, 4'd0,
        mk("R6 read default 2", 0, 0, 0, (8'h47 ^ 8'h5A) >> 6, 0, 0));

    // wedged write, zero bits, with reboot
    run(8'h58, 8'hFF, 3'd5, 1'b1, 4'd0, mk("R9 reboot write", 0, 0, 0, 0, 0, 1));
    chk(tbit == 0, "R7 zero data bits", tbit, 0);

    // reboot bit without a wedge bit: normal, no reset request
    run(8'h58, 8'h70, 3'd4, 1'b0, 4'd0, mk("R5 R9 mode 4", 0, 0, 0, 8'h70 ^ 8'h5A, ~8'h70, 0));
    chk(stops == 1, "R5 mode 4 stops", stops, 1);

    // clock stretching below the limit
    @(posedge clk); t_stretch = 20;
    run(8'h58, 8'h9E, 3'd0, 1'b0, 4'd0, mk("R10 stretch", 0, 0, 0, 8'h9E ^ 8'h5A, ~8'h9E, 0));
    @(posedge clk); t_stretch = 0;

    // SCL stuck low: timeout abandon
    @(posedge clk); t_stuck = 1'b1;
    run(8'h58, 8'h11, 3'd1, 1'b0, 4'd0, mk("R10 timeout", 1, 0, 0, 0, 0, 0));
    chk(!scl_oe && !sda_oe, "R10 lines released on timeout", {scl_oe, sda_oe}, 0);
    @(posedge clk); t_stuck = 1'b0;

    // go while busy is ignored
    begin
      int n0;
      tgt_clear();
      sb.push_back(mk("R11 busy go", 0, 0, 0, 8'h05 ^ 8'h5A, ~8'h05, 0));
      n0 = done_seen;
      issue(8'h58, 8'h05, 3'd0, 1'b0, 4'd0);
      repeat (40) @(negedge clk);
      issue(8'h58, 8'hEE, 3'd5, 1'b1, 4'd2);
      wait (done_seen != n0);
      repeat (2000) @(negedge clk);
      chk(done_seen == n0 + 1, "R11 single done", done_seen - n0, 1);
      chk(!busy, "R11 idle after ignored go", busy, 0);
    end

    report();
  end
endmodule